// File: doc/BRIEF.md
# Manual breakpoint halt controller

This block decides how a processor core responds when an external debugger raises its breakpoint pin. The pin is asynchronous. It is synchronized and edge-detected, and each rising edge is held as a pending request until the core reports that its current instruction has completed. The request is then issued. In normal mode it becomes a halt that lasts until a restart request arrives. When the interrupt-mode configuration bit is set, it becomes a one-cycle debug-interrupt pulse and the core keeps running.

While the core is halted, the 4-bit processor status output carries the halt code 0xF. At all other times it passes the core's own status code through unchanged. A read-only revision field reports which debug-architecture revision the block was built for, selected by a build-time parameter. From the second revision onward, activity of the serial debug command engine has no effect on the breakpoint logic. In the initial revision, a running debug command discards a request that has not yet been issued.

Top module: `brk_halt_ctrl`

## Requirements
- R1: `hw_rev` is a constant: 4'b0000 when built for the initial revision (A), 4'b0001 for revision B (the default), and 4'b1001 for revision B+.
- R2: After reset and with no breakpoint activity, `halt_req` and `dbg_irq` are 0 and `proc_status` equals `core_status`.
- R3: Call the first rising clock edge that samples `brk_pin` high edge 1. With `insn_done` high and `intr_mode` low, `halt_req` is 0 after edge 3 and 1 after edge 4.
- R4: A one-cycle pulse on `brk_pin` that arrives while `insn_done` is low is not lost. `halt_req` stays 0 until `insn_done` is seen high, and rises on the first clock edge that samples `insn_done` high.
- R5: While `halt_req` is 1, `proc_status` reads 4'hF. While it is 0, `proc_status` follows `core_status` combinationally.
- R6: Once raised, `halt_req` stays 1 for as long as `restart` is low. It returns to 0 after the first clock edge that samples `restart` high.
- R7: With `intr_mode` high, a breakpoint edge produces a `dbg_irq` pulse exactly one cycle long, at the timing of R3, and `halt_req` stays 0.
- R8: Only a rising edge of `brk_pin` makes a request. A pin held high causes a single halt, and it causes no further halt after a restart. Edges that arrive while the core is halted are dropped, so nothing is pending after the restart.
- R9: If `restart` and a new synchronized rising edge of `brk_pin` are sampled on the same clock edge, `halt_req` stays 1, and that edge leaves no request pending for after the next restart.
- R10: For revisions B and B+, `cmd_busy` has no effect: a pending request survives it. For revision A, a pending request that has not yet been issued is discarded while `cmd_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge active |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| brk_pin | input | 1 | Asynchronous external breakpoint request |
| insn_done | input | 1 | Core indication that the current instruction has completed |
| intr_mode | input | 1 | 1 = breakpoint raises a debug interrupt, 0 = breakpoint halts |
| restart | input | 1 | Request to leave the halted state |
| cmd_busy | input | 1 | Serial debug command in progress |
| core_status | input | 4 | Status code supplied by the core when not halted |
| halt_req | output | 1 | Halt request, held until restart |
| dbg_irq | output | 1 | One-cycle debug-interrupt request |
| proc_status | output | 4 | Processor status: 4'hF when halted, otherwise `core_status` |
| hw_rev | output | 4 | Debug-architecture revision code |

## Verification
A pin edge passes through two synchronizer flops, the edge detector and the pending register before it reaches the halt or interrupt flop. Halt and interrupt results are therefore due on the fourth clock edge after the pin is first sampled. A restart or a late `insn_done` acts on the very next edge. Each stimulus task records the cycle number at which every result is due. The monitor compares outputs one time unit after that exact edge, so an output that arrives a cycle early or a cycle late shows up as a mismatch. The restart/breakpoint collision is produced by raising `restart` in the cycle where the synchronized edge is live, which falls two edges after the pin rises.

// File: rtl/brk_halt_pkg.sv
package brk_halt_pkg;

   typedef enum logic [1:0] {
      DBG_REV_A  = 2'd0,
      DBG_REV_B  = 2'd1,
      DBG_REV_BP = 2'd2
   } dbg_rev_e;

   localparam int          STAT_W    = 4;
   localparam logic [3:0]  HALT_CODE = 4'hF;

   function automatic logic [3:0] rev_code(dbg_rev_e rev);
      logic [3:0] code;
      case (rev)
         DBG_REV_A:  code = 4'b0000;
         DBG_REV_B:  code = 4'b0001;
         DBG_REV_BP: code = 4'b1001;
         default:    code = 4'b0000;
      endcase
      return code;
   endfunction

endpackage

// File: rtl/brk_sync.sv
module brk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("brk_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/brk_edge_latch.sv
module brk_edge_latch
   import brk_halt_pkg::*;
#(
   parameter dbg_rev_e REV = DBG_REV_B
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   input  logic arm,
   input  logic take,
   input  logic cmd_busy,
   output logic rise,
   output logic pending
);

   logic prev_q;
   logic pend_q;
   logic drop;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_in;
   end

   assign rise = sync_in & ~prev_q;

   generate
      if (REV == DBG_REV_A) begin : g_cmd_clears
         assign drop = cmd_busy;

         // R10
         cmd_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_busy && !(rise && arm)) |=> !pend_q)
            else $error("revision A: command did not discard pending request");
      end else begin : g_cmd_ignored
         assign drop = 1'b0;

         // R10
         cmd_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_busy && pend_q && !take) |=> pend_q)
            else $error("command activity disturbed pending request");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)              pend_q <= 1'b0;
      else if (rise && arm)    pend_q <= 1'b1;
      else if (take || drop)   pend_q <= 1'b0;
   end

   assign pending = pend_q;

   // R8
   pend_needs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(rise) && $past(arm))
      else $error("pending set without an armed rising edge");

endmodule

// File: rtl/brk_halt_fsm.sv
module brk_halt_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic pending,
   input  logic rise,
   input  logic insn_done,
   input  logic intr_mode,
   input  logic restart,
   output logic fire,
   output logic halted,
   output logic irq
);

   logic halted_q;
   logic irq_q;
   logic halted_n;

   assign fire = pending & insn_done & ~halted_q;

   always_comb begin
      if (halted_q) halted_n = !(restart && !rise);
      else          halted_n = fire && !intr_mode;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halted_q <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         halted_q <= halted_n;
         irq_q    <= fire && intr_mode;
      end
   end

   assign halted = halted_q;
   assign irq    = irq_q;

   // R6
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_q && !restart) |=> halted_q)
      else $error("halt dropped without restart");

   // R4
   halt_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted_q) |-> $past(insn_done))
      else $error("halt issued before instruction completion");

   // R7
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q)
      else $error("debug interrupt longer than one cycle");

   // R7
   irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> ($past(intr_mode) && !halted_q))
      else $error("debug interrupt outside interrupt mode");

endmodule

// File: rtl/brk_halt_ctrl.sv
module brk_halt_ctrl
   import brk_halt_pkg::*;
#(
   parameter dbg_rev_e REV         = DBG_REV_B,
   parameter int       SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       brk_pin,
   input  logic       insn_done,
   input  logic       intr_mode,
   input  logic       restart,
   input  logic       cmd_busy,
   input  logic [3:0] core_status,
   output logic       halt_req,
   output logic       dbg_irq,
   output logic [3:0] proc_status,
   output logic [3:0] hw_rev
);

   generate
      if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("brk_halt_ctrl: SYNC_STAGES must be 2..4");
      end
   endgenerate

   logic pin_s;
   logic rise;
   logic pending;
   logic fire;
   logic halted;
   logic irq;

   brk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (brk_pin),
      .q_sync  (pin_s)
   );

   brk_edge_latch #(.REV(REV)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_in  (pin_s),
      .arm      (~halted),
      .take     (fire),
      .cmd_busy (cmd_busy),
      .rise     (rise),
      .pending  (pending)
   );

   brk_halt_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .pending   (pending),
      .rise      (rise),
      .insn_done (insn_done),
      .intr_mode (intr_mode),
      .restart   (restart),
      .fire      (fire),
      .halted    (halted),
      .irq       (irq)
   );

   assign halt_req    = halted;
   assign dbg_irq     = irq;
   assign proc_status = halted ? HALT_CODE : core_status;
   assign hw_rev      = rev_code(REV);

   // R3
   pend_before_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_req) |-> $past(pending))
      else $error("halt raised without a pending request");

   // R7
   halt_irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !($rose(halt_req) && dbg_irq))
      else $error("halt and interrupt issued together");

endmodule

// File: tb/brk_halt_ctrl_bench.sv
`timescale 1ns/1ps
module brk_halt_ctrl_bench;
   import brk_halt_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       brk_pin, insn_done, intr_mode, restart, cmd_busy;
   logic [3:0] core_status;
   logic       halt_req, dbg_irq;
   logic [3:0] proc_status, hw_rev;
   logic       ha, ia, hp, ip;
   logic [3:0] sa, ra, sp, rp;

   int tests = 0;
   int fails = 0;
   int cyc   = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   brk_halt_ctrl u_brk_halt_ctrl (
      .clk(clk), .rst_n(rst_n), .brk_pin(brk_pin), .insn_done(insn_done),
      .intr_mode(intr_mode), .restart(restart), .cmd_busy(cmd_busy),
      .core_status(core_status), .halt_req(halt_req), .dbg_irq(dbg_irq),
      .proc_status(proc_status), .hw_rev(hw_rev));

   brk_halt_ctrl #(.REV(DBG_REV_A)) u_rev_a (
      .clk(clk), .rst_n(rst_n), .brk_pin(brk_pin), .insn_done(insn_done),
      .intr_mode(intr_mode), .restart(restart), .cmd_busy(cmd_busy),
      .core_status(core_status), .halt_req(ha), .dbg_irq(ia),
      .proc_status(sa), .hw_rev(ra));

   brk_halt_ctrl #(.REV(DBG_REV_BP)) u_rev_bp (
      .clk(clk), .rst_n(rst_n), .brk_pin(brk_pin), .insn_done(insn_done),
      .intr_mode(intr_mode), .restart(restart), .cmd_busy(cmd_busy),
      .core_status(core_status), .halt_req(hp), .dbg_irq(ip),
      .proc_status(sp), .hw_rev(rp));

   typedef struct {
      int         at;
      logic       h;
      logic       irq;
      logic [3:0] st;
      string      req;
   } exp_t;

   exp_t sb[$];

   task automatic chk(string req, string what, int act, int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic push(int dly, logic h, logic irq, logic [3:0] st, string req);
      exp_t e;
      e.at = cyc + dly; e.h = h; e.irq = irq; e.st = st; e.req = req;
      sb.push_back(e);
   endtask

   task automatic drain();
      while (sb.size() > 0) @(negedge clk);
   endtask

   task automatic pulse_pin();
      brk_pin = 1'b1;
      @(negedge clk);
      brk_pin = 1'b0;
   endtask

   task automatic do_restart(string req);
      restart = 1'b1;
      push(1, 1'b0, 1'b0, core_status, req);
      @(negedge clk);
      restart = 1'b0;
      drain();
   endtask

   task automatic quiet(int n, string req);
      for (int i = 1; i <= n; i++) push(i, 1'b0, 1'b0, core_status, req);
      drain();
   endtask

   // monitor: compares each expected item one time unit after its edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            if (e.at < cyc) chk(e.req, "stale expectation", cyc, e.at);
            else begin
               chk(e.req, "halt_req", int'(halt_req), int'(e.h));
               chk(e.req, "dbg_irq", int'(dbg_irq), int'(e.irq));
               chk(e.req, "proc_status", int'(proc_status), int'(e.st));
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; brk_pin = 1'b0; insn_done = 1'b0; intr_mode = 1'b0;
      restart = 1'b0; cmd_busy = 1'b0; core_status = 4'h3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state
      chk("R2", "halt_req", int'(halt_req), 0);
      chk("R2", "dbg_irq", int'(dbg_irq), 0);
      chk("R2", "proc_status", int'(proc_status), 4'h3);
      // R1 revision codes
      chk("R1", "hw_rev B", int'(hw_rev), 4'b0001);
      chk("R1", "hw_rev A", int'(ra), 4'b0000);
      chk("R1", "hw_rev B+", int'(rp), 4'b1001);
      // R5 passthrough
      core_status = 4'h6; #1;
      chk("R5", "proc_status passthrough", int'(proc_status), 4'h6);

      // R3 basic halt timing
      @(negedge clk);
      insn_done = 1'b1;
      brk_pin = 1'b1;
      push(3, 1'b0, 1'b0, 4'h6, "R3");
      push(4, 1'b1, 1'b0, 4'hF, "R3");
      push(5, 1'b1, 1'b0, 4'hF, "R5");
      @(negedge clk);
      brk_pin = 1'b0;
      drain();
      core_status = 4'h9;
      for (int i = 1; i <= 6; i++) push(i, 1'b1, 1'b0, 4'hF, "R6");
      drain();
      do_restart("R6");

      // R4 request held while instruction not complete
      insn_done = 1'b0;
      for (int i = 1; i <= 9; i++) push(i, 1'b0, 1'b0, 4'h9, "R4");
      pulse_pin();
      drain();
      insn_done = 1'b1;
      push(1, 1'b1, 1'b0, 4'hF, "R4");
      drain();
      do_restart("R4");

      // R7 interrupt mode
      intr_mode = 1'b1;
      core_status = 4'h2;
      push(3, 1'b0, 1'b0, 4'h2, "R7");
      push(4, 1'b0, 1'b1, 4'h2, "R7");
      push(5, 1'b0, 1'b0, 4'h2, "R7");
      push(8, 1'b0, 1'b0, 4'h2, "R7");
      pulse_pin();
      drain();
      intr_mode = 1'b0;

      // R8 level-held pin: one halt only
      brk_pin = 1'b1;
      push(4, 1'b1, 1'b0, 4'hF, "R8");
      drain();
      repeat (3) @(negedge clk);
      do_restart("R8");
      quiet(6, "R8");
      brk_pin = 1'b0;
      repeat (3) @(negedge clk);

      // R8 edge while halted is dropped
      push(4, 1'b1, 1'b0, 4'hF, "R8");
      pulse_pin();
      drain();
      pulse_pin();
      repeat (6) @(negedge clk);
      do_restart("R8");
      quiet(6, "R8");

      // R9 restart and new edge in the same cycle
      push(4, 1'b1, 1'b0, 4'hF, "R9");
      pulse_pin();
      drain();
      repeat (2) @(negedge clk);
      brk_pin = 1'b1;
      @(negedge clk);
      brk_pin = 1'b0;
      @(negedge clk);
      restart = 1'b1;
      push(1, 1'b1, 1'b0, 4'hF, "R9");
      @(negedge clk);
      restart = 1'b0;
      for (int i = 1; i <= 5; i++) push(i, 1'b1, 1'b0, 4'hF, "R9");
      drain();
      do_restart("R9");
      quiet(6, "R9");

      // R10 command activity: ignored for B, discards for A
      insn_done = 1'b0;
      cmd_busy = 1'b1;
      pulse_pin();
      repeat (6) @(negedge clk);
      cmd_busy = 1'b0;
      @(negedge clk);
      insn_done = 1'b1;
      push(1, 1'b1, 1'b0, 4'hF, "R10");
      @(negedge clk);
      chk("R10", "rev B+ halt_req", int'(hp), 1);
      chk("R10", "rev A halt_req", int'(ha), 0);
      repeat (3) @(negedge clk);
      chk("R10", "rev A halt_req later", int'(ha), 0);
      chk("R10", "rev A proc_status", int'(sa), int'(core_status));
      drain();
      do_restart("R10");

      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule